// File: doc/BRIEF.md
# Polarity-Configurable Event Flag Aggregator

This block turns a set of status event lines into sticky flags that a host processor can read and clear, and merges a selectable subset of those flags into one combined level output for an interrupt controller. Each line has its own polarity bit. Most lines set their flag whenever they sit at the chosen level. The two comparator lines set their flag only on the chosen edge.

Flag 0 has no line of its own. It takes the OR of three wakeup inputs. The host reaches four registers through a single-cycle write port and a combinational read port: polarity, flags, mask and a write-only clear strobe. A flag clears when 0 is written to its bit in the flag register, or when 1 is written to its bit in the clear register. A level flag whose source is still active is set again at once.

Top module: `evt_flag_agg`

## Requirements
- R1: After reset the polarity, flag and mask registers read 0 and comb_o is low.
- R2: reg_addr selects the register: 0 polarity, 1 flags, 2 mask, 3 clear. A write with reg_wr high takes effect at the next clock edge. Polarity and mask read back bits 10:0 as written. Address 3 always reads 0.
- R3: Flag bits 10 to 3 and bit 0 are level flags. The flag is 1 after the first clock edge at which its source equals the active level, and it stays 1 after the source leaves that level. Polarity 0 means active high and polarity 1 means active low.
- R4: Flag bits 2 and 1 are edge flags. Polarity 0 sets the flag on a rising edge and polarity 1 sets it on a falling edge. The opposite edge and a static level have no effect. A cleared edge flag stays 0 while its source holds still.
- R5: The source of flag 0 is the OR of the three bits of wake_i. Any one of them alone sets the flag.
- R6: A write to the flag register clears every flag whose data bit is 0. A data bit of 1 leaves that flag unchanged and never sets it.
- R7: A write to the clear register clears every flag whose data bit is 1. A data bit of 0 has no effect.
- R8: If a level flag is cleared at an edge where its source is active, the set wins and the flag reads 1 afterwards.
- R9: comb_o is high in the same cycle in which any flag with mask bit 1 is set. It stays high until the last such flag clears.
- R10: A flag whose mask bit is 0 does not drive comb_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 10 | Event lines for flags 10..1 (bit n feeds flag n) |
| wake_i | input | 3 | Wakeup inputs ORed into flag 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data for reg_addr |
| comb_o | output | 1 | Masked OR of the flags |

## Verification
The assertions are checked on every cycle. They cover four points: an active level source forces its flag on the next cycle, a clear with the source inactive leaves a level flag at 0, a still source cannot raise an edge flag, and comb_o is low whenever the mask is zero. Some behaviour only the bench scenarios can show. These are the exact edge direction chosen by polarity, the difference between clearing an edge flag and a level flag while the source is active, and the different meaning of data bits in the flag register and in the clear register. The scenarios also show comb_o holding while a second included flag remains set.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  localparam int unsigned AGG_ADDR_W = 2;

  typedef enum logic [AGG_ADDR_W-1:0] {
    ADDR_POL  = 2'd0,
    ADDR_FLAG = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_CLR  = 2'd3
  } agg_addr_e;
endpackage

// File: rtl/evt_agg_regs.sv
module evt_agg_regs
  import evt_agg_pkg::*;
#(
  parameter int unsigned W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [AGG_ADDR_W-1:0] addr_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [W-1:0]          flags_i,
  output logic [W-1:0]          pol_o,
  output logic [W-1:0]          mask_o,
  output logic [W-1:0]          clr_o,
  output logic [W-1:0]          rdata_o
);
  logic [W-1:0] pol_q, pol_d;
  logic [W-1:0] mask_q, mask_d;
  logic         pol_we, mask_we, flag_we, clr_we;

  always_comb begin
    pol_we  = wr_i && (addr_i == ADDR_POL);
    mask_we = wr_i && (addr_i == ADDR_MASK);
    flag_we = wr_i && (addr_i == ADDR_FLAG);
    clr_we  = wr_i && (addr_i == ADDR_CLR);
    pol_d   = pol_we  ? wdata_i : pol_q;
    mask_d  = mask_we ? wdata_i : mask_q;
    clr_o   = ({W{flag_we}} & ~wdata_i) | ({W{clr_we}} & wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      mask_q <= '0;
    end else begin
      pol_q  <= pol_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_POL:  rdata_o = pol_q;
      ADDR_FLAG: rdata_o = flags_i;
      ADDR_MASK: rdata_o = mask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign pol_o  = pol_q;
  assign mask_o = mask_q;

  // R2
  pol_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADDR_POL) |=> (pol_o == $past(wdata_i)));
endmodule

// File: rtl/evt_agg_cell.sv
module evt_agg_cell #(
  parameter bit IS_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic hit;

  generate
    if (IS_EDGE) begin : g_edge
      logic prev_q;
      logic now_al, prev_al;
      always_comb begin
        now_al  = src_i ^ pol_i;
        prev_al = prev_q ^ pol_i;
        hit     = now_al & ~prev_al;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i;
      end

      // R4
      edge_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(src_i) && $stable(pol_i) && !flag_o) |=> !flag_o);
    end else begin : g_level
      always_comb hit = src_i ^ pol_i;

      // R3
      lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i ^ pol_i) |=> flag_o);
      // R7
      lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(src_i ^ pol_i)) |=> !flag_o);
    end
  endgenerate

  always_comb flag_d = hit | (flag_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/evt_flag_agg.sv
module evt_flag_agg
  import evt_agg_pkg::*;
#(
  parameter int unsigned        NUM_FLAGS = 11,
  parameter int unsigned        WAKE_W    = 3,
  parameter logic [NUM_FLAGS-1:0] EDGE_MASK = 11'h006
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FLAGS-1:1]  src_i,
  input  logic [WAKE_W-1:0]     wake_i,
  input  logic                  reg_wr,
  input  logic [AGG_ADDR_W-1:0] reg_addr,
  input  logic [NUM_FLAGS-1:0]  reg_wdata,
  output logic [NUM_FLAGS-1:0]  reg_rdata,
  output logic                  comb_o
);
  logic [NUM_FLAGS-1:0] src_all;
  logic [NUM_FLAGS-1:0] flags, pol, mask, clr;

  assign src_all = {src_i, |wake_i};

  evt_agg_regs #(.W(NUM_FLAGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .flags_i (flags),
    .pol_o   (pol),
    .mask_o  (mask),
    .clr_o   (clr),
    .rdata_o (reg_rdata)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
    evt_agg_cell #(.IS_EDGE(EDGE_MASK[g])) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_all[g]),
      .pol_i  (pol[g]),
      .clr_i  (clr[g]),
      .flag_o (flags[g])
    );
  end

  assign comb_o = |(flags & mask);

  // R5
  wake_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wake_i) && !pol[0]) |=> flags[0]);
  // R10
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !comb_o);
  // R9
  comb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_o |-> (flags != '0));
endmodule

// File: tb/evt_flag_agg_bench.sv
`timescale 1ns/1ps
module evt_flag_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:1] src;
  logic [2:0]  wake;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [10:0] reg_wdata;
  logic [10:0] reg_rdata;
  logic        comb_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [10:0] exp_rd_q[$];
  bit          exp_cb_q[$];
  string       tag_q[$];

  localparam logic [1:0] A_POL = 2'd0, A_FLAG = 2'd1, A_MASK = 2'd2, A_CLR = 2'd3;

  always #2.5 clk = ~clk;

  evt_flag_agg u_evt_flag_agg (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wake_i(wake),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .comb_o(comb_o)
  );

  // monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_rd_q.size() > 0) begin
        logic [10:0] er;
        bit          ec;
        string       t;
        er = exp_rd_q.pop_front();
        ec = exp_cb_q.pop_front();
        t  = tag_q.pop_front();
        total++;
        if (reg_rdata !== er) begin
          bad++;
          $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, er);
        end
        total++;
        if (comb_o !== ec) begin
          bad++;
          $display("FAIL %s comb_o actual=%b expected=%b", t, comb_o, ec);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [10:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic chk(input logic [1:0] a, input logic [10:0] er, input bit ec, input string t);
    @(negedge clk);
    reg_addr = a;
    exp_rd_q.push_back(er);
    exp_cb_q.push_back(ec);
    tag_q.push_back(t);
  endtask

  task automatic set_src(input int idx, input logic v);
    @(negedge clk);
    src[idx] = v;
  endtask

  task automatic set_wake(input logic [2:0] v);
    @(negedge clk);
    wake = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; wake = '0; reg_wr = 1'b0; reg_addr = A_POL; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk(A_POL,  11'h000, 1'b0, "R1 pol");
    chk(A_FLAG, 11'h000, 1'b0, "R1 flags");
    chk(A_MASK, 11'h000, 1'b0, "R1 mask");
    chk(A_CLR,  11'h000, 1'b0, "R2 clear reads 0");

    // level flag, active high
    set_src(5, 1'b1);
    chk(A_FLAG, 11'h020, 1'b0, "R3 level set");
    set_src(5, 1'b0);
    chk(A_FLAG, 11'h020, 1'b0, "R3 sticky");
    wr(A_MASK, 11'h020);
    chk(A_MASK, 11'h020, 1'b1, "R9 mask include");
    set_src(5, 1'b1);
    wr(A_CLR, 11'h020);
    chk(A_FLAG, 11'h020, 1'b1, "R8 set wins");
    set_src(5, 1'b0);
    wr(A_CLR, 11'h020);
    chk(A_FLAG, 11'h000, 1'b0, "R7 clear reg");

    // flag register write semantics
    set_src(7, 1'b1); set_src(9, 1'b1);
    set_src(7, 1'b0); set_src(9, 1'b0);
    chk(A_FLAG, 11'h280, 1'b0, "R3 two flags");
    wr(A_FLAG, 11'h600);
    chk(A_FLAG, 11'h200, 1'b0, "R6 write 0 clears");
    wr(A_CLR, 11'h000);
    chk(A_FLAG, 11'h200, 1'b0, "R7 zero no effect");
    wr(A_CLR, 11'h200);
    chk(A_FLAG, 11'h000, 1'b0, "R7 clear");

    // active-low level
    wr(A_POL, 11'h008);
    chk(A_POL,  11'h008, 1'b0, "R2 pol readback");
    chk(A_FLAG, 11'h008, 1'b0, "R3 active low");
    set_src(3, 1'b1);
    wr(A_CLR, 11'h008);
    chk(A_FLAG, 11'h000, 1'b0, "R3 low inactive");

    // edge flags
    set_src(1, 1'b1);
    chk(A_FLAG, 11'h002, 1'b0, "R4 rising");
    wr(A_CLR, 11'h002);
    chk(A_FLAG, 11'h000, 1'b0, "R4 no reset while high");
    set_src(1, 1'b0);
    chk(A_FLAG, 11'h000, 1'b0, "R4 falling ignored");
    wr(A_POL, 11'h00A);
    set_src(1, 1'b1);
    chk(A_FLAG, 11'h000, 1'b0, "R4 rising ignored");
    set_src(1, 1'b0);
    chk(A_FLAG, 11'h002, 1'b0, "R4 falling");
    wr(A_CLR, 11'h002);
    set_src(2, 1'b1);
    chk(A_FLAG, 11'h004, 1'b0, "R4 comparator b");
    set_src(2, 1'b0);
    wr(A_CLR, 11'h004);
    chk(A_FLAG, 11'h000, 1'b0, "R4 cleared");

    // wakeup OR
    for (int k = 0; k < 3; k++) begin
      set_wake(3'(1 << k));
      set_wake(3'b000);
      chk(A_FLAG, 11'h001, 1'b0, "R5 wake bit");
      wr(A_CLR, 11'h001);
      chk(A_FLAG, 11'h000, 1'b0, "R5 cleared");
    end

    // combined output
    set_wake(3'b001);
    wr(A_MASK, 11'h002);
    chk(A_FLAG, 11'h001, 1'b0, "R10 excluded");
    wr(A_MASK, 11'h001);
    chk(A_FLAG, 11'h001, 1'b1, "R9 included");
    set_src(1, 1'b1); set_src(1, 1'b0);
    wr(A_MASK, 11'h003);
    chk(A_FLAG, 11'h003, 1'b1, "R9 two set");
    set_wake(3'b000);
    wr(A_CLR, 11'h001);
    chk(A_FLAG, 11'h002, 1'b1, "R9 one remains");
    wr(A_CLR, 11'h002);
    chk(A_FLAG, 11'h000, 1'b0, "R9 none left");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule